// File: doc/BRIEF.md
# Page-Mode Parallel F-RAM Device Model

This block is a synthesizable, device-side model of a bytewide parallel ferroelectric RAM. A fast sampling clock runs it. It watches three active-low strobes (chip select, write strobe and output enable) together with the address and data lines. From these it works out what the external bus master is doing: a read, a write started by chip select, or a write started by the write strobe. It holds the bytes in an internal register array. The default array is 2K x 8. Widening the address parameter gives up to 32K x 8.

Access time, column access time and precharge time are counted in sampling-clock cycles. The output driver turns on only when output enable is low, the write strobe is high and the current access has completed. A write is committed at the moment its pulse ends. While chip select stays low, the master may change the column bits for a fast in-row access, or change the row bits for a new full access. An access that breaks the timing rules is dropped and reported with a one-cycle pulse on a violation output. Two cases count as breaking the rules: chip select falls again before precharge has finished, or a write pulse is too short.

Top module: `fram_bus_model`

## Requirements
- R1: When chip select is seen low after being high, with precharge complete, the address is latched. If the write strobe is high in that cycle, the cycle is a read and the latched byte is what later appears on `dq_o`.
- R2: If the write strobe is already low when chip select falls, the cycle is a chip-select-controlled write. The byte stored is the `dq_i` value sampled in the cycle where chip select is first seen high again.
- R3: If the write strobe falls while chip select is already low, the cycle has started as a read and may drive data. The write access starts at that falling edge and targets the address present on that edge.
- R4: `dq_oe_o` rises exactly `T_ACC` clock edges after the edge that samples the chip-select fall, provided output enable is low. Before then it stays low.
- R5: While the write strobe is low, `dq_oe_o` is 0 regardless of output enable.
- R6: While output enable is high, and after reset, `dq_oe_o` is 0.
- R7: A write ends on whichever of write strobe or chip select rises first. The byte is stored in that cycle and is readable straight afterwards.
- R8: With chip select held low, a change on the low `COL_W` address bits alone reloads a `T_PAGE`-cycle column access. A change on any higher bit reloads a full `T_ACC`-cycle access. In both cases the new address is used.
- R9: A chip-select fall sampled within `T_PRE` edges of the edge that sampled its rise is ignored: no drive and no write follow. `viol_o` goes high for exactly one cycle, one edge after that fall is sampled.
- R10: A write pulse sampled low on fewer than `T_ACC` edges is discarded, leaving memory unchanged, and `viol_o` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address; low COL_W bits select the column |
| dq_i | input | DATA_W | Data bus input |
| dq_o | output | DATA_W | Data bus output value |
| dq_oe_o | output | 1 | Data bus drive enable; high-impedance when 0 |
| viol_o | output | 1 | One-cycle pulse on a timing violation |

## Verification
The bench builds the block with a 512-byte array (`ADDR_W`=9), `T_ACC`=4, `T_PAGE`=2 and `T_PRE`=3. With these values, a random walk over the strobes often hits an early chip-select fall inside precharge and a write pulse shorter than the access time. The small row count lets random traffic write and then read back the same bytes, so data compares happen often. The short counts also make the exact cycle at which drive begins after a full access, a column access or a row change easy to pin down in the directed sequences.

// File: rtl/fram_pkg.sv
package fram_pkg;

  typedef struct packed {
    logic ce_fall;
    logic ce_rise;
    logic we_fall;
  } strb_ev_t;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/fram_strobe_edge.sv
module fram_strobe_edge
  import fram_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ce_ni,
  input  logic     we_ni,
  output strb_ev_t ev_o
);

  logic ce_p_q, we_p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_p_q <= 1'b1;
      we_p_q <= 1'b1;
    end else begin
      ce_p_q <= ce_ni;
      we_p_q <= we_ni;
    end
  end

  always_comb begin
    ev_o.ce_fall = ce_p_q & ~ce_ni;
    ev_o.ce_rise = ~ce_p_q & ce_ni;
    ev_o.we_fall = we_p_q & ~we_ni;
  end

endmodule

// File: rtl/fram_timer.sv
module fram_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fram_array.sv
module fram_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/fram_bus_model.sv
module fram_bus_model
  import fram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COL_W  = 3,
  parameter int unsigned T_ACC  = 4,
  parameter int unsigned T_PAGE = 2,
  parameter int unsigned T_PRE  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              viol_o
);

  localparam int unsigned ACC_MAX = (T_ACC > T_PAGE) ? T_ACC : T_PAGE;
  localparam int unsigned ACC_W   = cnt_w(ACC_MAX);
  localparam int unsigned PRE_W   = cnt_w(T_PRE);

  strb_ev_t ev;
  logic pre_zero, acc_zero;

  logic              active_q, wr_act_q, viol_q;
  logic [ADDR_W-1:0] addr_lat_q, wr_addr_q;
  logic [ACC_W-1:0]  wr_cnt_q;

  logic sel, start_acc, blocked, hi_chg, col_chg;
  logic wr_end, wr_ok, wr_start, acc_load;
  logic [ACC_W-1:0] acc_val;

  fram_strobe_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .we_ni  (we_ni),
    .ev_o   (ev)
  );

  // access-time counter: full or column reload
  fram_timer #(.W(ACC_W)) u_acc_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (acc_load),
    .load_val_i (acc_val),
    .zero_o     (acc_zero)
  );

  // precharge counter, armed on every chip-select rise
  fram_timer #(.W(PRE_W)) u_pre_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ev.ce_rise),
    .load_val_i (PRE_W'(T_PRE)),
    .zero_o     (pre_zero)
  );

  always_comb begin
    start_acc = ev.ce_fall & pre_zero;
    blocked   = ev.ce_fall & ~pre_zero;
    sel       = active_q & ~ce_ni;
    hi_chg    = sel & (addr_i[ADDR_W-1:COL_W] != addr_lat_q[ADDR_W-1:COL_W]);
    col_chg   = sel & ~hi_chg & (addr_i[COL_W-1:0] != addr_lat_q[COL_W-1:0]);
    acc_load  = start_acc | hi_chg | col_chg;
    acc_val   = col_chg ? ACC_W'(T_PAGE) : ACC_W'(T_ACC);
    wr_end    = wr_act_q & (we_ni | ce_ni);
    wr_ok     = wr_end & (wr_cnt_q >= ACC_W'(T_ACC));
    // strobe order picks the write flavour: select-led or strobe-led
    wr_start  = (start_acc & ~we_ni) | (sel & ev.we_fall);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      addr_lat_q <= '0;
      wr_act_q   <= 1'b0;
      wr_addr_q  <= '0;
      wr_cnt_q   <= '0;
      viol_q     <= 1'b0;
    end else begin
      if (ev.ce_rise)      active_q <= 1'b0;
      else if (start_acc)  active_q <= 1'b1;

      if (acc_load) addr_lat_q <= addr_i;

      if (wr_end)          wr_act_q <= 1'b0;
      else if (wr_start)   wr_act_q <= 1'b1;

      if (wr_start) begin
        wr_addr_q <= addr_i;
        wr_cnt_q  <= ACC_W'(1);
      end else if (wr_act_q && !wr_end && wr_cnt_q < ACC_W'(T_ACC)) begin
        wr_cnt_q  <= wr_cnt_q + 1'b1;
      end

      viol_q <= blocked | (wr_end & ~wr_ok);
    end
  end

  fram_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_ok),
    .waddr_i (wr_addr_q),
    .wdata_i (dq_i),
    .raddr_i (addr_lat_q),
    .rdata_o (dq_o)
  );

  assign dq_oe_o = active_q & acc_zero & ~ce_ni & ~oe_ni & we_ni;
  assign viol_o  = viol_q;

  a_r4_access_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc |=> !dq_oe_o);
  a_r5_we_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !dq_oe_o);
  a_r6_oe_high_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);
  a_r9_precharge_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.ce_rise |=> !pre_zero);
  a_r9_ignored_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> (viol_o && !dq_oe_o));
  a_r7_commit_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> !wr_ok);

endmodule

// File: tb/fram_bus_model_tb_top.sv
module fram_bus_model_tb_top;

  localparam int AW = 9, DW = 8, CW = 3;
  localparam int TA = 4, TP = 2, TR = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o, viol_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag = "R6";

  always #10 clk = ~clk;

  fram_bus_model #(.ADDR_W(AW), .DATA_W(DW), .COL_W(CW),
                   .T_ACC(TA), .T_PAGE(TP), .T_PRE(TR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .dq_i(dq_in), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .viol_o(viol_o));

  // behavioural reference
  bit [7:0] mem_m [int];
  int m_ce_p, m_we_p, m_act, m_lat, m_acc, m_pre, m_wr, m_wcnt, m_waddr, m_viol;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ce_p = 1; m_we_p = 1; m_act = 0; m_lat = 0; m_acc = 0;
      m_pre = 0; m_wr = 0; m_wcnt = 0; m_waddr = 0; m_viol = 0;
    end else begin
      int c, w, a;
      c = int'(ce); w = int'(we); a = int'(addr);
      m_viol = 0;
      if (m_wr == 1 && (w == 1 || c == 1)) begin
        if (m_wcnt >= TA) mem_m[m_waddr] = dq_in;
        else m_viol = 1;
        m_wr = 0;
      end else if (m_wr == 1) m_wcnt++;
      if (m_ce_p == 1 && c == 0) begin
        if (m_pre > 0) m_viol = 1;
        else begin
          m_act = 1; m_lat = a; m_acc = TA;
          if (w == 0) begin m_wr = 1; m_wcnt = 1; m_waddr = a; end
        end
      end else if (m_act == 1 && c == 0) begin
        if (m_we_p == 1 && w == 0) begin m_wr = 1; m_wcnt = 1; m_waddr = a; end
        if ((a >> CW) != (m_lat >> CW)) begin m_lat = a; m_acc = TA; end
        else if (a != m_lat) begin m_lat = a; m_acc = TP; end
        else if (m_acc > 0) m_acc--;
      end
      if (m_ce_p == 0 && c == 1) begin m_act = 0; m_pre = TR; end
      else if (m_pre > 0) m_pre--;
      m_ce_p = c; m_we_p = w;
    end
  end

  task automatic fail_msg(string req, string what, int act, int exp);
    n_err++;
    $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) fail_msg(req, what, act, exp);
  endtask

  task automatic compare();
    int exp_oe;
    exp_oe = (m_act == 1 && m_acc == 0 && !ce && !oe && we) ? 1 : 0;
    chk(tag, "model drive", int'(dq_oe_o), exp_oe);
    chk(tag, "model viol", int'(viol_o), m_viol);
    if (exp_oe == 1 && mem_m.exists(m_lat))
      chk(tag, "model data", int'(dq_o), int'(mem_m[m_lat]));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic recover();
    repeat (TR + 1) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    chk("R6", "reset drive", int'(dq_oe_o), 0);
    chk("R6", "reset viol", int'(viol_o), 0);

    // R2 select-led write, oe held low to show R5
    tag = "R2"; addr = 9'h012; we = 0; oe = 0; dq_in = 8'h3C; step();
    ce = 0; repeat (5) step();
    chk("R5", "drive during write", int'(dq_oe_o), 0);
    ce = 1; step(); we = 1; oe = 1; recover();

    // R1/R4 read
    tag = "R4"; ce = 0; oe = 0; addr = 9'h012;
    repeat (TA) step();
    chk("R4", "drive before access", int'(dq_oe_o), 0);
    step();
    chk("R4", "drive at access", int'(dq_oe_o), 1);
    chk("R1", "read data", int'(dq_o), 8'h3C);
    oe = 1; step();
    chk("R6", "oe high", int'(dq_oe_o), 0);
    ce = 1; recover();

    // R3 strobe-led write
    tag = "R3"; ce = 0; oe = 0; addr = 9'h055; repeat (5) step();
    chk("R3", "starts as read", int'(dq_oe_o), 1);
    we = 0; dq_in = 8'h5A; step();
    chk("R5", "we low quiet", int'(dq_oe_o), 0);
    repeat (4) step();
    we = 1; step();
    chk("R7", "drive after write", int'(dq_oe_o), 1);
    chk("R7", "written data", int'(dq_o), 8'h5A);
    ce = 1; oe = 1; recover();

    // R8 page writes then page reads
    tag = "R8"; ce = 0; addr = 9'h060; repeat (5) step();
    for (int c = 0; c < 4; c++) begin
      addr = 9'h060 + 9'(c); we = 0; dq_in = 8'h10 + 8'(c);
      repeat (TA) step();
      we = 1; step();
    end
    ce = 1; recover();
    ce = 0; oe = 0; addr = 9'h060; repeat (5) step();
    chk("R8", "col0 data", int'(dq_o), 8'h10);
    addr = 9'h063; step(); step();
    chk("R8", "column wait", int'(dq_oe_o), 0);
    step();
    chk("R8", "column drive", int'(dq_oe_o), 1);
    chk("R8", "col3 data", int'(dq_o), 8'h13);
    addr = 9'h012; repeat (TA) step();
    chk("R8", "row wait", int'(dq_oe_o), 0);
    step();
    chk("R8", "row data", int'(dq_o), 8'h3C);

    // R9 early select
    tag = "R9"; ce = 1; step(); ce = 0; step();
    chk("R9", "viol pulse", int'(viol_o), 1);
    step();
    chk("R9", "viol one cycle", int'(viol_o), 0);
    repeat (6) step();
    chk("R9", "ignored no drive", int'(dq_oe_o), 0);
    ce = 1; oe = 1; recover();

    // R10 short write
    tag = "R10"; ce = 0; addr = 9'h012; repeat (5) step();
    we = 0; dq_in = 8'hFF; repeat (2) step();
    we = 1; step();
    chk("R10", "short viol", int'(viol_o), 1);
    oe = 0; step();
    chk("R10", "data kept", int'(dq_o), 8'h3C);
    ce = 1; oe = 1; recover();

    // R7 write ended by select first
    tag = "R7"; ce = 0; addr = 9'h070; repeat (5) step();
    we = 0; dq_in = 8'h77; repeat (5) step();
    ce = 1; step(); we = 1; recover();
    ce = 0; oe = 0; repeat (5) step();
    chk("R7", "select-ended write", int'(dq_o), 8'h77);
    ce = 1; oe = 1; recover();

    // random traffic against the reference
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      step();
      if ($urandom_range(7) == 0) ce = ~ce;
      if ($urandom_range(5) == 0) we = ~we;
      if ($urandom_range(4) == 0) oe = ~oe;
      if ($urandom_range(5) == 0) addr[CW-1:0] = 3'($urandom);
      if ($urandom_range(11) == 0) addr = 9'($urandom);
      dq_in = 8'($urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      fail_msg("R1", "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule